// File: doc/BRIEF.md
# Indirect Register Window Bridge

This bridge gives a host CPU with a narrow bus access to a wide internal register space through four direct addresses. The host first loads a 16-bit register index through one or two byte-wide index locations. It then reads or writes an 8-bit data window. Each completed access to the data window becomes exactly one transfer on an internal register-file port, addressed by the stored index. The index does not step after an access, so repeated window accesses reach the same register.

The host interface runs in either a byte-lane (narrow) mode or a 16-bit (wide) mode, chosen by a static mode pin. In narrow mode the two index bytes are written separately. In wide mode a single write loads the whole index. In both modes the data window carries 8 bits.

Both request paths use valid/ready. A host request completes in a cycle where `cpu_valid` and `cpu_ready` are both high. Index and unmapped locations are always ready. A data-window request is ready only when the register file asserts `rf_ready`, which is how the register file applies back-pressure to the host. While a request is waiting, the host must keep `cpu_write`, `cpu_addr` and `cpu_wdata` unchanged. The register-file request `rf_valid` stays high for as long as the data-window request is pending. The register file returns read data in the same cycle as the handshake.

Top module: `regwin_bridge`

## Requirements
- R1: While reset is asserted and after it is released, the index is 0, so `rf_addr` reads 0x0000.
- R2: In narrow mode (`bus_wide`=0), a completed write to address 0 loads index bits [7:0] from `cpu_wdata[7:0]` and leaves bits [15:8] unchanged.
- R3: In narrow mode, a completed write to address 1 loads index bits [15:8] from `cpu_wdata[7:0]` and leaves bits [7:0] unchanged.
- R4: In wide mode (`bus_wide`=1), a completed write to address 0 loads all 16 index bits from `cpu_wdata[15:0]`.
- R5: In wide mode, a write to address 1 has no effect on the index.
- R6: A read of address 0, 1 or 3 returns 0x0000 on `cpu_rdata`, does not change the index and raises no register-file request. A write to address 3 is ignored.
- R7: A request to address 0, 1 or 3 sees `cpu_ready`=1 in the same cycle.
- R8: A request to address 2 drives `rf_valid`=1, with `rf_write` equal to `cpu_write` and `rf_wdata` equal to `cpu_wdata[7:0]`. `cpu_ready` follows `rf_ready`, so each handshake is one register-file transfer.
- R9: In the handshake cycle of a data-window read, `cpu_rdata` equals {8'h00, `rf_rdata`}. In every other cycle it is 0x0000.
- R10: A data-window access leaves the index unchanged (no auto-increment).
- R11: `rf_addr` always equals the current index.
- R12: While `rf_ready` is low, a pending data-window request keeps `rf_valid` high with a stable address and write data. No transfer completes until `rf_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wide | input | 1 | 1: 16-bit host mode, 0: byte-lane host mode |
| cpu_valid | input | 1 | Host request valid |
| cpu_ready | output | 1 | Host request accepted this cycle |
| cpu_write | input | 1 | 1 write, 0 read |
| cpu_addr | input | 2 | Direct address: 0 index low, 1 index high, 2 data window, 3 unmapped |
| cpu_wdata | input | 16 | Host write data |
| cpu_rdata | output | 16 | Host read data, valid in the read handshake cycle |
| rf_valid | output | 1 | Register-file request valid |
| rf_ready | input | 1 | Register-file ready |
| rf_write | output | 1 | Register-file request is a write |
| rf_addr | output | 16 | Register index |
| rf_wdata | output | 8 | Register-file write data |
| rf_rdata | input | 8 | Register-file read data, same cycle as handshake |

## Verification
The bench targets the difference between the two modes. A design that always loads the full bus into the index would corrupt the upper byte when a narrow-mode low-byte write carries stray upper bits. A design that honours address 1 in wide mode would change the index when it should not. The bench also stretches data-window requests with random `rf_ready` stalls. A bridge that strobed the register file before the handshake, or committed a write twice, would leave the mirrored register contents wrong and return bad read data. Back-to-back window accesses expose any index auto-increment. Reads of the write-only and unmapped addresses expose any leaked data or spurious register-file requests.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int IDX_W  = 16;
  localparam int DATA_W = 8;
  localparam int BUS_W  = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    WIN_IDX_LO = 2'd0,
    WIN_IDX_HI = 2'd1,
    WIN_DATA   = 2'd2,
    WIN_NONE   = 2'd3
  } win_e;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int NLANE     = 2,
  parameter int BUS_LANES = 2
) (
  input  logic              valid,
  input  logic              write,
  input  logic              wide,
  input  logic              rf_ready,
  input  logic [ADDR_W-1:0] addr,
  output logic [NLANE-1:0]  ld_lane,
  output logic              dat_sel,
  output logic              dat_rd,
  output logic              ready
);
  logic is_data;
  logic hs;

  always_comb begin
    is_data = (win_e'(addr) == WIN_DATA);
    ready   = is_data ? rf_ready : 1'b1;
    hs      = valid && ready;
    dat_sel = valid && is_data;
    dat_rd  = hs && is_data && !write;
  end

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic narrow_hit;
    logic wide_hit;
    always_comb begin
      narrow_hit = (addr == ADDR_W'(i));
      wide_hit   = (win_e'(addr) == WIN_IDX_LO) && (i < BUS_LANES);
      ld_lane[i] = hs && write && (wide ? wide_hit : narrow_hit);
    end
  end
endmodule

// File: rtl/regwin_index.sv
module regwin_index
  import regwin_pkg::*;
#(
  parameter int NLANE     = 2,
  parameter int BUS_LANES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wide,
  input  logic [NLANE-1:0]       ld_lane,
  input  logic [BUS_W-1:0]       bus,
  output logic [NLANE*DATA_W-1:0] idx
);
  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    localparam int SRC_LO = (i < BUS_LANES) ? i * DATA_W : 0;
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] lane_q;

    always_comb src = wide ? bus[SRC_LO +: DATA_W] : bus[DATA_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lane_q <= '0;
      else if (ld_lane[i]) lane_q <= src;
    end

    assign idx[i*DATA_W +: DATA_W] = lane_q;
  end
endmodule

// File: rtl/regwin_datapath.sv
module regwin_datapath
  import regwin_pkg::*;
(
  input  logic              dat_sel,
  input  logic              dat_rd,
  input  logic              write,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_valid,
  output logic              rf_write,
  output logic [IDX_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic [BUS_W-1:0]  rdata
);
  localparam int PAD_W = BUS_W - DATA_W;

  always_comb begin
    rf_valid = dat_sel;
    rf_write = write;
    rf_addr  = idx;
    rf_wdata = wdata[DATA_W-1:0];
    rdata    = dat_rd ? {{PAD_W{1'b0}}, rf_rdata} : '0;
  end
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wide,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BUS_W-1:0]  cpu_wdata,
  output logic [BUS_W-1:0]  cpu_rdata,
  output logic              rf_valid,
  input  logic              rf_ready,
  output logic              rf_write,
  output logic [IDX_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  input  logic [DATA_W-1:0] rf_rdata
);
  localparam int NLANE     = IDX_W / DATA_W;
  localparam int BUS_LANES = BUS_W / DATA_W;

  logic [NLANE-1:0] ld_lane;
  logic             dat_sel;
  logic             dat_rd;
  logic [IDX_W-1:0] idx;

  regwin_decode #(.NLANE(NLANE), .BUS_LANES(BUS_LANES)) u_dec (
    .valid(cpu_valid), .write(cpu_write), .wide(bus_wide), .rf_ready(rf_ready),
    .addr(cpu_addr), .ld_lane(ld_lane), .dat_sel(dat_sel), .dat_rd(dat_rd),
    .ready(cpu_ready)
  );

  regwin_index #(.NLANE(NLANE), .BUS_LANES(BUS_LANES)) u_idx (
    .clk(clk), .rst_n(rst_n), .wide(bus_wide), .ld_lane(ld_lane),
    .bus(cpu_wdata), .idx(idx)
  );

  regwin_datapath u_dp (
    .dat_sel(dat_sel), .dat_rd(dat_rd), .write(cpu_write), .wdata(cpu_wdata),
    .idx(idx), .rf_rdata(rf_rdata), .rf_valid(rf_valid), .rf_write(rf_write),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rdata(cpu_rdata)
  );

  // R7
  idx_port_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_addr != WIN_DATA) |-> cpu_ready);

  // R6
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_write && cpu_addr != WIN_DATA) |-> (cpu_rdata == '0 && !rf_valid));

  // R9
  win_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && !cpu_write && cpu_addr == WIN_DATA)
      |-> (cpu_rdata[DATA_W-1:0] == rf_rdata && cpu_rdata[BUS_W-1:DATA_W] == '0));

  // R10
  no_autoinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && cpu_addr == WIN_DATA) |=> $stable(rf_addr));

  // R5
  wide_hi_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_write && bus_wide && cpu_addr == WIN_IDX_HI) |=> $stable(rf_addr));

  // R3
  narrow_hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_write && !bus_wide && cpu_addr == WIN_IDX_HI)
      |=> (rf_addr[IDX_W-1:DATA_W] == $past(cpu_wdata[DATA_W-1:0])
           && rf_addr[DATA_W-1:0] == $past(rf_addr[DATA_W-1:0])));

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && !rf_ready) |=> (rf_valid && $stable(rf_addr) && $stable(rf_wdata)));
endmodule

// File: tb/regwin_bridge_tb_top.sv
module regwin_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wide = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_ready;
  logic        cpu_write = 1'b0;
  logic [1:0]  cpu_addr = 2'd0;
  logic [15:0] cpu_wdata = 16'h0;
  logic [15:0] cpu_rdata;
  logic        rf_valid;
  logic        rf_ready = 1'b1;
  logic        rf_write;
  logic [15:0] rf_addr;
  logic [7:0]  rf_wdata;
  logic [7:0]  rf_rdata;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  regwin_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wide(bus_wide), .cpu_valid(cpu_valid),
    .cpu_ready(cpu_ready), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rf_valid(rf_valid),
    .rf_ready(rf_ready), .rf_write(rf_write), .rf_addr(rf_addr),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  // register file model (environment)
  logic [7:0] rf_mem [0:1023];
  logic [7:0] ref_mem [0:1023];
  assign rf_rdata = rf_mem[rf_addr[9:0]];
  always @(posedge clk)
    if (rf_valid && rf_ready && rf_write) rf_mem[rf_addr[9:0]] <= rf_wdata;

  bit        stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA7;
  always @(posedge clk) begin
    lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rf_ready <= stall_en ? lfsr[0] : 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_idx = 16'h0;
  string       m_tag = "R1";
  logic [15:0] n_idx = 16'h0;
  string       n_tag = "R1";
  bit          n_wr = 1'b0;
  logic [9:0]  n_wa;
  logic [7:0]  n_wd;

  always @(negedge clk) begin
    bit          is_dat;
    bit          e_rdy;
    bit          e_rfv;
    logic [15:0] e_rd;
    is_dat = (cpu_addr == 2'd2);
    e_rdy  = is_dat ? rf_ready : 1'b1;
    e_rfv  = cpu_valid && is_dat;
    e_rd   = (cpu_valid && !cpu_write && is_dat && rf_ready) ? {8'h00, ref_mem[m_idx[9:0]]} : 16'h0;
    // R11: address always tracks the index; tag names the op that set it
    chk(m_tag, 32'(rf_addr), 32'(m_idx));
    if (rst_n) begin
      chk(is_dat ? "R8" : "R7", 32'(cpu_ready), 32'(e_rdy));
      chk(rf_ready ? "R8" : "R12", 32'(rf_valid), 32'(e_rfv));
      if (e_rfv) begin
        chk("R8", 32'(rf_write), 32'(cpu_write));
        chk("R8", 32'(rf_wdata), 32'(cpu_wdata[7:0]));
      end
      chk(is_dat ? "R9" : "R6", 32'(cpu_rdata), 32'(e_rd));
    end
    n_idx = m_idx; n_tag = m_tag; n_wr = 1'b0; n_wa = m_idx[9:0]; n_wd = cpu_wdata[7:0];
    if (!rst_n) begin
      n_idx = 16'h0; n_tag = "R1";
    end else if (cpu_valid && e_rdy) begin
      case (cpu_addr)
        2'd0: if (!cpu_write) n_tag = "R6";
              else if (bus_wide) begin n_idx = cpu_wdata; n_tag = "R4"; end
              else begin n_idx[7:0] = cpu_wdata[7:0]; n_tag = "R2"; end
        2'd1: if (!cpu_write) n_tag = "R6";
              else if (bus_wide) n_tag = "R5";
              else begin n_idx[15:8] = cpu_wdata[7:0]; n_tag = "R3"; end
        2'd2: begin n_tag = "R10"; n_wr = cpu_write; end
        default: n_tag = "R6";
      endcase
    end
  end

  always @(posedge clk) begin
    m_idx <= n_idx;
    m_tag <= n_tag;
    if (n_wr) ref_mem[n_wa] <= n_wd;
  end

  task automatic acc(input bit w, input logic [1:0] a, input logic [15:0] d);
    cpu_valid <= 1'b1; cpu_write <= w; cpu_addr <= a; cpu_wdata <= d;
    do @(negedge clk); while (!cpu_ready);
    @(posedge clk);
    cpu_valid <= 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      rf_mem[i]  = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst_n <= 1'b1;
    repeat (3) @(posedge clk);
    // narrow mode index loading and data window (R2 R3 R8 R9 R10)
    acc(1'b1, 2'd0, 16'hFF34);
    acc(1'b1, 2'd1, 16'hEE02);
    acc(1'b1, 2'd2, 16'h11A5);
    acc(1'b0, 2'd2, 16'h0);
    acc(1'b0, 2'd2, 16'h0);
    // write-only and unmapped locations (R6 R7)
    acc(1'b0, 2'd0, 16'h0);
    acc(1'b0, 2'd1, 16'h0);
    acc(1'b0, 2'd3, 16'h0);
    acc(1'b1, 2'd3, 16'h5555);
    acc(1'b0, 2'd2, 16'h0);
    // wide mode (R4 R5)
    bus_wide <= 1'b1;
    acc(1'b1, 2'd0, 16'hAB55);
    acc(1'b1, 2'd1, 16'h0077);
    acc(1'b1, 2'd2, 16'hC33C);
    acc(1'b0, 2'd2, 16'h0);
    acc(1'b1, 2'd0, 16'h0155);
    acc(1'b0, 2'd2, 16'h0);
    // back to narrow: low byte write with stray upper bits (R2)
    bus_wide <= 1'b0;
    acc(1'b1, 2'd0, 16'hFF12);
    acc(1'b0, 2'd2, 16'h0);
    // random traffic with register-file stalls (R12)
    stall_en <= 1'b1;
    for (int k = 0; k < 300; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[20:16] == 5'd0) bus_wide <= ~bus_wide;
      acc(r[8], r[1:0], r[31:16]);
      if (r[9]) @(posedge clk);
    end
    stall_en <= 1'b0;
    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule